// File: doc/BRIEF.md
# External Watchdog Monitor with Keyed Service Window

This block watches a piece of software from outside. Once enabled, an 8-bit counter advances on every clock. Software must service the monitor by writing a two-byte key to the service register. The service counts only while the counter sits inside a window bounded by two compare registers. A service that lands too early, a counter that runs past the upper bound, or an external input that goes to its active level pulls the active-low fault output low. The fault output then stays low until the next reset.

Four byte-wide registers sit on a small register bus: control, service, compare-low and compare-high. The control register can be written only once after reset. This lets boot code fix the enable, the external-input enable and its polarity so that nothing can undo them later. The compare registers stay writable, so the window can be adjusted at run time.

Top module: `wdm_monitor`

## Requirements
- R1: After reset `fault_n` is 1, control reads 0x00, compare-low reads 0x00, compare-high reads 0xFF and the service register reads 0x00.
- R2: Register offsets on `bus_addr` are: 0 control, 1 service, 2 compare-low, 3 compare-high. A byte written to either compare register reads back unchanged.
- R3: Only the first write to control after reset takes effect, and every later control write is ignored. Only control bits 0, 2 and 3 are stored, and the other bits read 0.
- R4: Control bit 0 enables the monitor. While it is 0 the counter holds at zero and `fault_n` stays 1, whatever the compare values or the service writes.
- R5: Once enabled, the counter rises by one on every clock and saturates at 0xFF. If the control write is edge 0, the counter holds m after edge m. When the counter exceeds compare-high, `fault_n` falls on the following edge. With compare-high = H it falls at edge H+2.
- R6: A valid service is a write of 0xB4 to the service register followed, on the next bus write, by 0x2C to the service register. If, in the cycle of that second write, the counter lies in [compare-low, compare-high] inclusive, the counter returns to zero on that edge.
- R7: A valid service whose counter value lies below compare-low pulls `fault_n` low on the edge of the second key write.
- R8: A pending first key byte is discarded by any following write that is not 0x2C to the service register. This includes a write to another register and a repeated 0xB4. A 0x2C with no key byte pending does nothing.
- R9: Control bit 3 enables the external input, and control bit 2 selects its active level (1 = high, 0 = low). The input passes through a two-stage synchronizer. An active level present before edge 1 pulls `fault_n` low at edge 3, and only while the monitor is enabled.
- R10: Once `fault_n` is low it stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_in | input | 1 | External fault input, asynchronous |
| fault_n | output | 1 | Active-low fault, sticky until reset |

## Verification
Each result arrives after a fixed delay:
- **Service key.** The decision is taken in the cycle of the second key write. An early service therefore shows at the first sample after that write, and a valid service shows as the absence of a later timeout.
- **Timeout.** `fault_n` falls two edges after the counter reaches compare-high. The bench counts edges from the control write and samples on the falling edge just before and just after that edge.
- **External input.** Its path is three edges deep. The bench samples after the second and after the third edge following the change of `ext_in`.
- **Table scenarios.** These use a wide window so that a one-cycle skew cannot flip their outcome. The exact edge counts are checked only in the directed tests.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_SVC   = 2'd1;
  localparam logic [1:0] OFS_CMPLO = 2'd2;
  localparam logic [1:0] OFS_CMPHI = 2'd3;

  localparam logic [REG_W-1:0] KEY_FIRST  = 8'hB4;
  localparam logic [REG_W-1:0] KEY_SECOND = 8'h2C;

  localparam int CB_EN   = 0;
  localparam int CB_POL  = 2;
  localparam int CB_INEN = 3;

  // counter lies within the inclusive service window
  function automatic logic in_window(input logic [REG_W-1:0] c,
                                     input logic [REG_W-1:0] lo,
                                     input logic [REG_W-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // counter has run beyond the upper bound
  function automatic logic past_limit(input logic [REG_W-1:0] c,
                                      input logic [REG_W-1:0] hi);
    return c > hi;
  endfunction

  // synchronized input matches the selected active level
  function automatic logic ext_active(input logic sample, input logic pol);
    return sample == pol;
  endfunction
endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
  import wdm_pkg::*;
#(
  parameter logic [REG_W-1:0] LO_INIT = 8'h00,
  parameter logic [REG_W-1:0] HI_INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic             mon_en,
  output logic             in_pol,
  output logic             in_en,
  output logic [REG_W-1:0] cmp_lo,
  output logic [REG_W-1:0] cmp_hi,
  output logic [REG_W-1:0] rdata
);
  logic ctrl_locked;
  logic ctrl_wr;

  assign ctrl_wr = we && (addr == OFS_CTRL) && !ctrl_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_locked <= 1'b0;
      mon_en      <= 1'b0;
      in_pol      <= 1'b0;
      in_en       <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_locked <= 1'b1;
      mon_en      <= wdata[CB_EN];
      in_pol      <= wdata[CB_POL];
      in_en       <= wdata[CB_INEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo <= LO_INIT;
      cmp_hi <= HI_INIT;
    end else if (we) begin
      if (addr == OFS_CMPLO) cmp_lo <= wdata;
      if (addr == OFS_CMPHI) cmp_hi <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[CB_EN]   = mon_en;
        rdata[CB_POL]  = in_pol;
        rdata[CB_INEN] = in_en;
      end
      OFS_CMPLO: rdata = cmp_lo;
      OFS_CMPHI: rdata = cmp_hi;
      default:   rdata = '0;
    endcase
  end

  // R3
  ctrl_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_locked && we && addr == OFS_CTRL) |=> $stable({mon_en, in_pol, in_en}));
endmodule

// File: rtl/wdm_key.sv
module wdm_key
  import wdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic             svc_done
);
  logic armed;
  logic first_hit;

  assign first_hit = we && (addr == OFS_SVC) && (wdata == KEY_FIRST);
  assign svc_done  = armed && we && (addr == OFS_SVC) && (wdata == KEY_SECOND);

  // any write while armed ends the pending sequence; arming needs a clean start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed <= 1'b0;
    else if (we) armed <= !armed && first_hit;
  end

  // R8
  key_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && we) |=> !armed);
  // R6
  key_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && first_hit) |=> armed);
endmodule

// File: rtl/wdm_counter.sv
module wdm_counter
  import wdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [REG_W-1:0] limit,
  output logic [REG_W-1:0] cnt,
  output logic             overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clear)                cnt <= '0;
    else if (run && (cnt != '1))   cnt <= cnt + 1'b1;
  end

  assign overrun = past_limit(cnt, limit);

  // R5
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cnt >= $past(cnt));
endmodule

// File: rtl/wdm_sync.sv
module wdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= 1'b0;
        else        s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wdm_monitor.sv
module wdm_monitor
  import wdm_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] LO_INIT     = 8'h00,
  parameter logic [REG_W-1:0] HI_INIT     = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ext_in,
  output logic             fault_n
);
  logic             mon_en, in_pol, in_en;
  logic [REG_W-1:0] cmp_lo, cmp_hi, cnt;
  logic             svc_done, overrun, ext_sync;
  logic             svc_ok, svc_bad, timeout, ext_trip, fault_q;

  wdm_regs #(.LO_INIT(LO_INIT), .HI_INIT(HI_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .mon_en(mon_en), .in_pol(in_pol), .in_en(in_en),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .rdata(bus_rdata)
  );

  wdm_key u_key (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .svc_done(svc_done)
  );

  wdm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(mon_en), .clear(svc_ok),
    .limit(cmp_hi), .cnt(cnt), .overrun(overrun)
  );

  wdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .q(ext_sync)
  );

  // named fault events
  assign svc_ok   = mon_en && svc_done &&  in_window(cnt, cmp_lo, cmp_hi);
  assign svc_bad  = mon_en && svc_done && !in_window(cnt, cmp_lo, cmp_hi);
  assign timeout  = mon_en && overrun;
  assign ext_trip = mon_en && in_en && ext_active(ext_sync, in_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_q | svc_bad | timeout | ext_trip;
  end

  assign fault_n = !fault_q;

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |=> !fault_n);
  // R6
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> cnt == '0);
  // R7
  svc_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_bad |=> !fault_n);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (fault_n && cnt == '0));
  // R9
  ext_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trip |=> !fault_n);
  // R5
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !fault_n);
endmodule

// File: tb/sim_wdm_monitor.sv
module sim_wdm_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       fault_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wdm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .fault_n(fault_n)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [7:0] b1;
    logic [1:0] a2;
    logic [7:0] d2;
    logic       has3;
    logic [1:0] a3;
    logic [7:0] d3;
    logic       now_ok;
    logic       late_ok;
  } vec_t;

  // window 20..60; pre = idle cycles after enabling
  localparam vec_t VECS [6] = '{
    '{8'd30, 8'hB4, 2'd1, 8'h2C, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1},  // in-window service
    '{8'd3,  8'hB4, 2'd1, 8'h2C, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0},  // early service
    '{8'd30, 8'hB4, 2'd1, 8'h2D, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0},  // wrong second byte
    '{8'd30, 8'hB4, 2'd2, 8'h14, 1'b1, 2'd1, 8'h2C, 1'b1, 1'b0},  // other write between
    '{8'd30, 8'h2C, 2'd1, 8'hB4, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0},  // bytes reversed
    '{8'd30, 8'hB4, 2'd1, 8'hB4, 1'b1, 2'd1, 8'h2C, 1'b1, 1'b0}   // repeated first byte
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; ext_in = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_fault(input logic exp, input string req);
    chk(fault_n === exp, req, fault_n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    do_reset();

    // R1 reset state
    expect_fault(1'b1, "R1 fault_n after reset");
    rd(2'd0, rv); chk(rv == 8'h00, "R1 control", rv, 8'h00);
    rd(2'd1, rv); chk(rv == 8'h00, "R1 service", rv, 8'h00);
    rd(2'd2, rv); chk(rv == 8'h00, "R1 compare-low", rv, 8'h00);
    rd(2'd3, rv); chk(rv == 8'hFF, "R1 compare-high", rv, 8'hFF);

    // R2 compare readback
    wr(2'd2, 8'h5A); wr(2'd3, 8'hA7);
    rd(2'd2, rv); chk(rv == 8'h5A, "R2 compare-low readback", rv, 8'h5A);
    rd(2'd3, rv); chk(rv == 8'hA7, "R2 compare-high readback", rv, 8'hA7);

    // R3 write-once and reserved bits
    wr(2'd0, 8'hF2);
    rd(2'd0, rv); chk(rv == 8'h00, "R3 reserved bits read zero", rv, 8'h00);
    wr(2'd0, 8'h0D);
    rd(2'd0, rv); chk(rv == 8'h00, "R3 second control write ignored", rv, 8'h00);

    // R4 disabled monitor never faults even with a tiny limit and an early key
    do_reset();
    wr(2'd3, 8'd5); wr(2'd2, 8'd50);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hB4); wr(2'd1, 8'h2C);
    idle(20);
    expect_fault(1'b1, "R4 disabled stays quiet");
    wr(2'd0, 8'h01);
    idle(20);
    expect_fault(1'b1, "R3 R4 late enable ignored");

    // R5 timeout edge: H=5, fault at edge 7 after the control write
    do_reset();
    wr(2'd3, 8'd5);
    wr(2'd0, 8'h01);
    idle(6);
    expect_fault(1'b1, "R5 before timeout edge");
    idle(1);
    expect_fault(1'b0, "R5 at timeout edge");
    // R10 sticky
    idle(30);
    expect_fault(1'b0, "R10 fault stays low");
    wr(2'd0, 8'h01); wr(2'd3, 8'hFF);
    idle(3);
    expect_fault(1'b0, "R10 writes do not clear fault");

    // R5 saturation with limit 0xFF never trips
    do_reset();
    wr(2'd0, 8'h01);
    idle(300);
    expect_fault(1'b1, "R5 saturating counter at 0xFF");

    // R9 active-high external input
    do_reset();
    wr(2'd0, 8'h0D);
    idle(3);
    expect_fault(1'b1, "R9 input idle");
    ext_in = 1'b1;
    idle(2);
    expect_fault(1'b1, "R9 high before third edge");
    idle(1);
    expect_fault(1'b0, "R9 high at third edge");

    // R9 active-low external input
    do_reset();
    ext_in = 1'b1;
    idle(3);
    wr(2'd0, 8'h09);
    idle(5);
    expect_fault(1'b1, "R9 low polarity idle level");
    ext_in = 1'b0;
    idle(2);
    expect_fault(1'b1, "R9 low before third edge");
    idle(1);
    expect_fault(1'b0, "R9 low at third edge");

    // R9 input disabled
    do_reset();
    wr(2'd0, 8'h05);
    ext_in = 1'b1;
    idle(10);
    expect_fault(1'b1, "R9 input disabled");

    // R6 R7 R8 service scenarios
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(2'd2, 8'd20); wr(2'd3, 8'd60);
      wr(2'd0, 8'h01);
      idle(int'(VECS[i].pre));
      wr(2'd1, VECS[i].b1);
      wr(VECS[i].a2, VECS[i].d2);
      if (VECS[i].has3) wr(VECS[i].a3, VECS[i].d3);
      chk(fault_n === VECS[i].now_ok, $sformatf("R6 R7 R8 vector %0d right after key", i),
          fault_n, VECS[i].now_ok);
      idle(40);
      chk(fault_n === VECS[i].late_ok, $sformatf("R5 R6 R8 vector %0d after 40 cycles", i),
          fault_n, VECS[i].late_ok);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule